// File: doc/BRIEF.md
# Strobe-Driven FIFO with Read Rewind

This block is a 512-entry, 9-bit-wide first-in first-out buffer that a producer and a consumer drive with active-low strobes instead of a valid/ready handshake. A high-to-low transition of the write strobe claims a slot, and the word on the data input is stored when that strobe returns high. A high-to-low transition of the read strobe presents the oldest stored word. No address is supplied: circular read and write pointers step through the storage on their own. Each word holds eight data bits and one spare bit that is free for parity or control use.

All strobes are asynchronous to the block. Each one passes through a two-stage synchronizer and an edge detector on the system clock, so one strobe pulse causes at most one access. An occupancy count tells a full buffer from an empty one when the two pointers meet. From it come the active-low empty and full flags, and those flags block reads on an empty buffer and writes on a full one. A rewind strobe moves the read pointer back to location 0 and leaves the write pointer alone, so data can be sent again. The rewind is accepted only while both access strobes are idle and the cascade-mode input is low. An output-enable shows when the read strobe is held low, so the data output can drive a shared tri-state bus.

Top module: `strobe_fifo`

## Requirements
- R1: While reset is held low and after it is released, with no access since, empty_n is 0, full_n is 1 and dout_oe is 0.
- R2: Words come out of dout in the order they were written, with all 9 bits intact.
- R3: A write strobe that falls while full_n is 0 is ignored: it stores nothing and moves no pointer. full_n goes to 0 when the 512th word is stored.
- R4: A read strobe that falls while empty_n is 0 is ignored: the next read after a later write returns that written word.
- R5: empty_n rises after a completed write into an empty buffer, and it falls when a read takes the last stored word.
- R6: full_n returns to 1 after a read from a full buffer.
- R7: The stored word is the value on din when wr_n rises, not the value present when wr_n fell.
- R8: dout_oe is 1 while the synchronized read strobe is low and 0 while it is high. During an accepted read, dout holds the word being read.
- R9: A rewind moves the read pointer to location 0 and leaves the write pointer unchanged. The occupancy becomes the write pointer value, or 512 when the write pointer has wrapped back to 0 after a full buffer.
- R10: A rewind is ignored while rd_n is low, while wr_n is low, or while cascade_mode is 1.
- R11: Holding rd_n low for many cycles causes exactly one read.
- R12: The pointers wrap from location 511 to 0, and order is preserved across many wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| rewind_n | input | 1 | Active-low rewind strobe for the read pointer |
| cascade_mode | input | 1 | 1 disables rewind (cascaded use) |
| din | input | 9 | Write data, captured when wr_n rises |
| dout | output | 9 | Read data |
| dout_oe | output | 1 | Output-enable for dout, high while the read strobe is low |
| empty_n | output | 1 | Low when nothing is stored |
| full_n | output | 1 | Low when 512 words are stored |

## Verification
The hardest state to reach is a rewind issued when the write pointer has wrapped back exactly to location 0. There the pointer difference is zero, yet the buffer must come back as full rather than empty. The stimulus fills all 512 slots after reset, drains three words and then rewinds. The bench then checks that full_n is low and that all 512 words replay in order. The stimulus also places rewinds inside open read and write strobes and in cascade mode, and proves each one was ignored by the data returned by the next read.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
    // strobe lane indices inside the synchronizer bank
    localparam int LANE_RD    = 0;
    localparam int LANE_WR    = 1;
    localparam int LANE_RW    = 2;
    localparam int LANE_COUNT = 3;

    typedef struct packed {
        logic level;  // synchronized strobe level (1 = inactive)
        logic fall;   // one-cycle pulse on high-to-low transition
        logic rise;   // one-cycle pulse on low-to-high transition
        logic idle;   // high now and high the cycle before
    } strobe_ev_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output strobe_fifo_pkg::strobe_ev_t ev_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.sh   = {s_q.sh[STAGES-2:0], strobe_n};
        s_d.prev = s_q.sh[STAGES-1];
        if (!rst_n) begin
            s_d = '1;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    always_comb begin
        ev_o.level = s_q.sh[STAGES-1];
        ev_o.fall  = s_q.prev & ~s_q.sh[STAGES-1];
        ev_o.rise  = ~s_q.prev & s_q.sh[STAGES-1];
        ev_o.idle  = s_q.prev & s_q.sh[STAGES-1];
    end

    // one edge pulse per transition
    assert_edge_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o.fall |=> !ev_o.fall);
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rdata_d, rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_d = re ? mem[raddr] : rdata_q;
        if (!rst_n) begin
            rdata_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_fifo_pkg::strobe_ev_t rd_ev,
    input  strobe_fifo_pkg::strobe_ev_t wr_ev,
    input  strobe_fifo_pkg::strobe_ev_t rw_ev,
    input  logic          cascade_mode,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic          empty_n,
    output logic          full_n
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] rptr;
        logic [AW-1:0] wptr;
        logic [CW-1:0] count;
        logic          wr_armed;
        logic          wrapped;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  rd_go, wr_go, rew_go, wr_arm;

    always_comb begin
        rd_go  = rd_ev.fall && (c_q.count != '0);
        wr_arm = wr_ev.fall && (c_q.count != FULL_CNT);
        wr_go  = wr_ev.rise && c_q.wr_armed;
        rew_go = rw_ev.fall && rd_ev.idle && wr_ev.idle && !cascade_mode && !c_q.wr_armed;

        c_d = c_q;
        if (wr_arm) begin
            c_d.wr_armed = 1'b1;
        end else if (wr_ev.rise) begin
            c_d.wr_armed = 1'b0;
        end

        if (rd_go) begin
            c_d.rptr = (c_q.rptr == LAST_PTR) ? '0 : c_q.rptr + AW'(1);
        end
        if (wr_go) begin
            c_d.wptr = (c_q.wptr == LAST_PTR) ? '0 : c_q.wptr + AW'(1);
            if (c_q.wptr == LAST_PTR) begin
                c_d.wrapped = 1'b1;
            end
        end

        if (rew_go) begin
            c_d.rptr = '0;
            if (c_q.wptr == '0) begin
                c_d.count = c_q.wrapped ? FULL_CNT : '0;
            end else begin
                c_d.count = {1'b0, c_q.wptr};
            end
        end else if (wr_go && !rd_go) begin
            c_d.count = c_q.count + CW'(1);
        end else if (rd_go && !wr_go) begin
            c_d.count = c_q.count - CW'(1);
        end

        if (!rst_n) begin
            c_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign we      = wr_go;
    assign waddr   = c_q.wptr;
    assign re      = rd_go;
    assign raddr   = c_q.rptr;
    assign empty_n = (c_q.count != '0);
    assign full_n  = (c_q.count != FULL_CNT);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.count <= FULL_CNT);
    assert_full_blocks_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !rd_go && !rew_go) |=> !full_n);
    assert_empty_blocks_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !wr_go && !rew_go) |=> !empty_n);
    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~empty_n, ~full_n}));
    assert_rewind_keeps_wptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rew_go |=> (c_q.rptr == '0) && $stable(c_q.wptr));
    assert_rewind_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_ev.fall && (cascade_mode || !rd_ev.idle || !wr_ev.idle)) |=> $stable(c_q.count) || $past(rd_go) || $past(wr_go));
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
    parameter int DEPTH  = 512,
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             rewind_n,
    input  logic             cascade_mode,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe,
    output logic             empty_n,
    output logic             full_n
);
    import strobe_fifo_pkg::*;
    localparam int AW = $clog2(DEPTH);

    logic [LANE_COUNT-1:0] lane_n;
    strobe_ev_t            ev [LANE_COUNT];
    logic                  we, re;
    logic [AW-1:0]         waddr, raddr;

    always_comb begin
        lane_n          = '1;
        lane_n[LANE_RD] = rd_n;
        lane_n[LANE_WR] = wr_n;
        lane_n[LANE_RW] = rewind_n;
    end

    for (genvar g = 0; g < LANE_COUNT; g++) begin : g_lane
        strobe_sync #(.STAGES(STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_n (lane_n[g]),
            .ev_o     (ev[g])
        );
    end

    fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_ev        (ev[LANE_RD]),
        .wr_ev        (ev[LANE_WR]),
        .rw_ev        (ev[LANE_RW]),
        .cascade_mode (cascade_mode),
        .we           (we),
        .waddr        (waddr),
        .re           (re),
        .raddr        (raddr),
        .empty_n      (empty_n),
        .full_n       (full_n)
    );

    fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .re    (re),
        .raddr (raddr),
        .rdata (dout)
    );

    assign dout_oe = ~ev[LANE_RD].level;

    assert_oe_idle_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dout_oe);
endmodule

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;
    localparam int N = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_n = 1'b1, wr_n = 1'b1, rewind_n = 1'b1, cascade_mode = 1'b0;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       dout_oe, empty_n, full_n;

    always #2 clk = ~clk;

    strobe_fifo u_strobe_fifo (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .rewind_n(rewind_n),
        .cascade_mode(cascade_mode), .din(din), .dout(dout), .dout_oe(dout_oe),
        .empty_n(empty_n), .full_n(full_n)
    );

    // behavioural reference
    logic [8:0] mm [N];
    int rp, wp, cnt, tw;
    int errs = 0, checks = 0;
    bit cmp_en = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (cmp_en) begin
            chk("R5 empty flag", 32'(empty_n), 32'(cnt != 0));
            chk("R3/R6 full flag", 32'(full_n), 32'(cnt != N));
        end
    end

    task automatic settle(input int n = 5);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [8:0] pat(input int i);
        return 9'(i * 37 + 5);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        cmp_en = 0;
        rst_n = 0; rd_n = 1; wr_n = 1; rewind_n = 1; cascade_mode = 0;
        settle(4);
        chk("R1 empty in reset", 32'(empty_n), 0);
        chk("R1 full in reset", 32'(full_n), 1);
        rst_n = 1;
        settle();
        rp = 0; wp = 0; cnt = 0; tw = 0;
        chk("R1 empty after reset", 32'(empty_n), 0);
        chk("R1 full after reset", 32'(full_n), 1);
        chk("R1 oe after reset", 32'(dout_oe), 0);
        cmp_en = 1;
    endtask

    task automatic do_write(input logic [8:0] v, input logic [8:0] early);
        @(negedge clk);
        cmp_en = 0;
        din = early; wr_n = 0;
        settle();
        din = v; wr_n = 1;
        settle();
        if (cnt < N) begin
            mm[wp] = v; wp = (wp + 1) % N; cnt++; tw++;
        end
        cmp_en = 1;
    endtask

    task automatic do_read(input int hold = 5);
        @(negedge clk);
        cmp_en = 0;
        rd_n = 0;
        settle(hold);
        chk("R8 oe while reading", 32'(dout_oe), 1);
        if (cnt > 0) begin
            chk("R2 order", 32'(dout), 32'(mm[rp]));
            rp = (rp + 1) % N; cnt--;
        end
        rd_n = 1;
        settle();
        chk("R8 oe released", 32'(dout_oe), 0);
        cmp_en = 1;
    endtask

    task automatic do_rewind();
        @(negedge clk);
        cmp_en = 0;
        rewind_n = 0;
        settle();
        rewind_n = 1;
        settle();
        if (!cascade_mode && rd_n && wr_n) begin
            rp = 0;
            cnt = (wp == 0) ? ((tw > 0) ? N : 0) : wp;
        end
        cmp_en = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        do_reset();

        // R4: read on empty is ignored
        do_read();
        chk("R4 still empty", 32'(empty_n), 0);
        // R7: value at rising wr_n is stored
        do_write(9'h155, 9'h0AA);
        chk("R5 empty cleared by write", 32'(empty_n), 1);
        do_read();
        chk("R7 last read value", 32'(dout), 32'h155);

        // R11: long read strobe takes one word
        do_write(9'h101, 9'h000);
        do_write(9'h0F0, 9'h000);
        do_read(40);
        chk("R11 one word taken", 32'(dout), 32'h101);
        do_read();
        chk("R11 second word next", 32'(dout), 32'h0F0);

        // R3, R6, R12: fill, overflow, wrap
        do_reset();
        for (int i = 0; i < N; i++) do_write(pat(i), ~pat(i));
        chk("R3 full at 512", 32'(full_n), 0);
        for (int i = 0; i < 3; i++) do_write(9'h1FF, 9'h000);
        chk("R3 still full after extra writes", 32'(full_n), 0);
        do_read();
        chk("R6 full cleared by read", 32'(full_n), 1);
        do_write(9'h033, 9'h000);
        while (cnt > 0) do_read();
        chk("R5 empty after drain", 32'(empty_n), 0);

        // R9: rewind replays from location 0, write pointer kept
        do_reset();
        for (int i = 0; i < 10; i++) do_write(pat(i + 100), 9'h000);
        for (int i = 0; i < 4; i++) do_read();
        do_rewind();
        chk("R9 rewind count", 32'(empty_n), 1);
        for (int i = 0; i < 10; i++) do_read();
        do_write(9'h0C3, 9'h000);
        do_write(9'h13C, 9'h000);
        do_read();
        chk("R9 append after rewind", 32'(dout), 32'h0C3);
        do_read();

        // R9: rewind with the write pointer wrapped to 0
        do_reset();
        for (int i = 0; i < N; i++) do_write(pat(i + 7), 9'h000);
        for (int i = 0; i < 3; i++) do_read();
        do_rewind();
        chk("R9 wrapped rewind gives full", 32'(full_n), 0);
        while (cnt > 0) do_read();

        // R10: rewind ignored in cascade mode, with wr_n low, with rd_n low
        do_reset();
        for (int i = 0; i < 5; i++) do_write(pat(i + 200), 9'h000);
        do_read(); do_read();
        cascade_mode = 1;
        do_rewind();
        cascade_mode = 0;
        do_read();
        chk("R10 cascade rewind ignored", 32'(dout), 32'(pat(202)));
        @(negedge clk); cmp_en = 0;
        din = 9'h077; wr_n = 0; settle();
        do_rewind();
        @(negedge clk); cmp_en = 0;
        wr_n = 1; settle();
        mm[wp] = 9'h077; wp++; cnt++; tw++;
        cmp_en = 1;
        do_read();
        chk("R10 rewind during write ignored", 32'(dout), 32'(pat(203)));
        @(negedge clk); cmp_en = 0;
        rd_n = 0; settle();
        chk("R10 read under rewind", 32'(dout), 32'(pat(204)));
        rp++; cnt--;
        do_rewind();
        @(negedge clk); cmp_en = 0;
        rd_n = 1; settle();
        cmp_en = 1;
        do_read();
        chk("R10 rewind during read ignored", 32'(dout), 32'h077);

        // R12: many wraps with interleaving
        do_reset();
        for (int i = 0; i < 1500; i++) begin
            do_write(pat(i * 3 + 11), 9'h000);
            if (i % 3 != 0) do_read();
        end
        while (cnt > 0) do_read();
        chk("R12 drained after wraps", 32'(empty_n), 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule